// File: doc/BRIEF.md
# Host Bridge Control Register File

This block is the control and status register bank of a host bridge. It holds 28 words of 32 bits. They cover power-on and general configuration, IO device and SDRAM timing, PCI mapping, GPIO, mailboxes, cache-control words and an interrupt controller. Each word sits at a 4-byte aligned byte offset from 0x00 to 0x6C.

A requester drives a one-cycle request with a byte offset, a write flag and write data. The decode result and the read data come back in the same cycle, and writes take effect at the clock edge.

Most words simply store what is written. The interrupt-enable word is different: software cannot write it directly. It changes only through a set alias and a clear alias. The interrupt status word is read-only and shows the raw interrupt lines. A 0-to-1 change of the CPU self-reset bit in the general configuration word raises a one-cycle system reset request. A bus reset loads fixed values into the configuration words.

Top module: `bridge_ctrl_regs`

## Requirements
- R1: After reset the bank holds the following values, and every other word reads 0:
  - offset 0x00: 0x00000C40
  - offset 0x04: 0x00001384 (bits 2, 7, 8, 9 and 12 set)
  - offset 0x08: 0x2BFF8010
  - offset 0x0C: 0x255E0091
  - offset 0x10: 0x00006140
  - offsets 0x1C and 0x20: 0x000001FF
  - offset 0x68: 0x00000008
  - offset 0x6C: 0x10000000
- R2: A write to any plain stored word (every mapped offset except 0x30, 0x34, 0x38 and 0x3C) is read back unchanged at that offset.
- R3: A write to offset 0x30 stores the data at 0x30 and ORs the data into the enable word at 0x38.
- R4: A write to offset 0x34 stores the data at 0x34 and clears in the enable word at 0x38 every bit that is 1 in the data.
- R5: Direct writes to offset 0x38 (enable) and offset 0x3C (status) change neither word.
- R6: A write to offset 0x04 that takes bit 2 from 0 to 1 makes `sys_reset_req` high for exactly the one cycle after the write edge.
- R7: A write to offset 0x04 while bit 2 is already 1, or a write to any other offset, raises no reset request.
- R8: An offset of 0x70 or above, or one with bits [1:0] non-zero, gives `hit` low and read data 0, and a write there changes no word.
- R9: A request to an aligned offset from 0x00 to 0x6C gives `hit` high in the same cycle.
- R10: Offset 0x3C reads the value of `irq_lines` sampled at the previous clock edge.
- R11: `int_enable` always equals the enable word that is read at offset 0x38.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, loads the defined values |
| req | input | 1 | Access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, 0 on a miss or during a write |
| hit | output | 1 | The request decoded to a mapped word |
| irq_lines | input | 32 | Raw interrupt lines shown in the status word |
| int_enable | output | 32 | Current interrupt-enable word |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The assertions take for granted that a request lasts one cycle, carries a known write flag and offset, and holds `wdata` stable during a write. They also assume that reset is released only at a clock edge after the reset values have loaded. The bench drives every access on the falling edge and drops `req` after one cycle, so back-to-back accesses never overlap. It moves `irq_lines` only between accesses, so the status word is always sampled one edge before it is read.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
   localparam int DATA_W     = 32;
   localparam int NUM_WORDS  = 28;
   localparam int IDX_W      = $clog2(NUM_WORDS);
   localparam int IDX_GENCFG = 1;
   localparam int IDX_EN_SET = 12;
   localparam int IDX_EN_CLR = 13;
   localparam int IDX_EN     = 14;
   localparam int IDX_STATUS = 15;
   localparam int SELF_RESET_BIT = 2;

   function automatic logic [DATA_W-1:0] reset_word(input int idx);
      case (idx)
         0:       return 32'h0000_0C40;
         1:       return 32'h0000_1384;
         2:       return 32'h2BFF_8010;
         3:       return 32'h255E_0091;
         4:       return 32'h0000_6140;
         7, 8:    return 32'h0000_01FF;
         26:      return 32'h0000_0008;
         27:      return 32'h1000_0000;
         default: return '0;
      endcase
   endfunction
endpackage

// File: rtl/bcr_addr_decode.sv
module bcr_addr_decode
   import bcr_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              req,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [IDX_W-1:0]  idx
);
   localparam int WIDX_W = ADDR_W - 2;

   logic [WIDX_W-1:0] word_sel;
   logic              aligned;
   logic              in_range;

   assign word_sel = addr[ADDR_W-1:2];
   assign aligned  = (addr[1:0] == 2'b00);
   assign in_range = (word_sel < WIDX_W'(NUM_WORDS));
   assign hit      = req && aligned && in_range;
   assign idx      = IDX_W'(word_sel);
endmodule

// File: rtl/bcr_word_bank.sv
module bcr_word_bank
   import bcr_pkg::*;
#(
   parameter bit SYNC_STATUS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] irq_lines,
   output logic [DATA_W-1:0] words [NUM_WORDS]
);
   logic wr_set, wr_clr;
   assign wr_set = wr_en && (wr_idx == IDX_W'(IDX_EN_SET));
   assign wr_clr = wr_en && (wr_idx == IDX_W'(IDX_EN_CLR));

   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
      if (i == IDX_EN) begin : g_enable
         logic [DATA_W-1:0] en_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      en_q <= reset_word(i);
            else if (wr_set) en_q <= en_q | wdata;
            else if (wr_clr) en_q <= en_q & ~wdata;
         end
         assign words[i] = en_q;

         // R3: every set-alias bit is present afterwards
         a_r3_set_ors: assert property (@(posedge clk) disable iff (!rst_n)
            wr_set |=> ((en_q & $past(wdata)) == $past(wdata)));
         // R4: every clear-alias bit is gone afterwards
         a_r4_clr_clears: assert property (@(posedge clk) disable iff (!rst_n)
            wr_clr |=> ((en_q & $past(wdata)) == '0));
         // R5: no alias write, no change
         a_r5_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_set || wr_clr) |=> $stable(en_q));
      end else if (i == IDX_STATUS) begin : g_status
         if (SYNC_STATUS) begin : g_sync
            logic [DATA_W-1:0] st_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) st_q <= '0;
               else        st_q <= irq_lines;
            end
            assign words[i] = st_q;
            // R10: status follows the lines one edge later
            a_r10_status_follow: assert property (@(posedge clk) disable iff (!rst_n)
               1'b1 |=> (st_q == $past(irq_lines)));
         end else begin : g_comb
            assign words[i] = irq_lines;
         end
      end else begin : g_plain
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                q <= reset_word(i);
            else if (wr_en && wr_idx == IDX_W'(i))     q <= wdata;
         end
         assign words[i] = q;
      end
   end
endmodule

// File: rtl/bcr_reset_trigger.sv
module bcr_reset_trigger
   import bcr_pkg::*;
#(
   parameter int TRIG_BIT = SELF_RESET_BIT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [DATA_W-1:0] cfg_new,
   input  logic [DATA_W-1:0] cfg_old,
   output logic              pulse
);
   logic fire;
   assign fire = cfg_wr && cfg_new[TRIG_BIT] && !cfg_old[TRIG_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse <= 1'b0;
      else        pulse <= fire;
   end

   // R6: request lasts one cycle
   a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);
   // R6: after the pulse the bit is set
   a_r6_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |-> cfg_old[TRIG_BIT]);
   // R7: a pulse needs a config write in the cycle before
   a_r7_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr |=> !pulse);
endmodule

// File: rtl/bridge_ctrl_regs.sv
module bridge_ctrl_regs
   import bcr_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter bit SYNC_STATUS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic              hit,
   input  logic [31:0]       irq_lines,
   output logic [31:0]       int_enable,
   output logic              sys_reset_req
);
   initial begin
      assert (ADDR_W >= $clog2(NUM_WORDS * 4))
         else $error("ADDR_W too small for the register window");
   end

   logic [IDX_W-1:0]  idx;
   logic              wr_en;
   logic [DATA_W-1:0] words [NUM_WORDS];

   bcr_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .req  (req),
      .addr (addr),
      .hit  (hit),
      .idx  (idx)
   );

   assign wr_en = hit && we;

   bcr_word_bank #(.SYNC_STATUS(SYNC_STATUS)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_idx    (idx),
      .wdata     (wdata),
      .irq_lines (irq_lines),
      .words     (words)
   );

   bcr_reset_trigger u_trig (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_wr  (wr_en && idx == IDX_W'(IDX_GENCFG)),
      .cfg_new (wdata),
      .cfg_old (words[IDX_GENCFG]),
      .pulse   (sys_reset_req)
   );

   assign rdata      = (hit && !we) ? words[idx] : '0;
   assign int_enable = words[IDX_EN];

   // R8: a miss never returns data
   a_r8_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (rdata == '0));
   // R9: aligned in-window requests always decode
   a_r9_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (req && addr[1:0] == 2'b00 && addr < ADDR_W'(NUM_WORDS * 4)) |-> hit);
endmodule

// File: tb/tb_bridge_ctrl_regs.sv
module tb_bridge_ctrl_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic        we = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        hit;
   logic [31:0] irq_lines = '0;
   logic [31:0] int_enable;
   logic        sys_reset_req;

   int n_checks = 0;
   int n_fail = 0;
   logic [31:0] rv;
   logic        rh;

   always #2.5 clk = ~clk;

   bridge_ctrl_regs dut (
      .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
      .wdata(wdata), .rdata(rdata), .hit(hit), .irq_lines(irq_lines),
      .int_enable(int_enable), .sys_reset_req(sys_reset_req)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      req = 1'b1; we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      req = 1'b0; we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a);
      @(negedge clk);
      req = 1'b1; we = 1'b0; addr = a;
      #1;
      rv = rdata; rh = hit;
      @(negedge clk);
      req = 1'b0;
   endtask

   task automatic t_reset_values;
      logic [31:0] exp;
      for (int i = 0; i < 28; i++) begin
         case (i)
            0: exp = 32'h0C40;  1: exp = 32'h1384;
            2: exp = 32'h2BFF8010; 3: exp = 32'h255E0091;
            4: exp = 32'h6140;  7, 8: exp = 32'h1FF;
            26: exp = 32'h8;    27: exp = 32'h10000000;
            default: exp = 0;
         endcase
         rd(8'(i * 4));
         check($sformatf("R1 reset word %0d", i), rv, exp);
      end
      check("R11 enable after reset", int_enable, 32'h0);
   endtask

   task automatic t_plain_rw;
      wr(8'h40, 32'hDEADBEEF);
      rd(8'h40); check("R2 mailbox readback", rv, 32'hDEADBEEF);
      check("R9 hit on mapped read", {31'd0, rh}, 32'd1);
      wr(8'h6C, 32'h0123_4567);
      rd(8'h6C); check("R2 last word readback", rv, 32'h0123_4567);
      wr(8'h10, 32'h0);
      rd(8'h10); check("R2 zero write", rv, 32'h0);
   endtask

   task automatic t_enable_set;
      wr(8'h30, 32'h0000_00F0);
      rd(8'h38); check("R3 enable after set", rv, 32'h0000_00F0);
      rd(8'h30); check("R3 set alias stored", rv, 32'h0000_00F0);
      wr(8'h30, 32'h8000_000F);
      rd(8'h38); check("R3 set ORs", rv, 32'h8000_00FF);
      check("R11 enable port", int_enable, 32'h8000_00FF);
   endtask

   task automatic t_enable_clear;
      wr(8'h34, 32'h8000_0030);
      rd(8'h38); check("R4 enable after clear", rv, 32'h0000_00CF);
      rd(8'h34); check("R4 clear alias stored", rv, 32'h8000_0030);
      check("R11 enable port after clear", int_enable, 32'h0000_00CF);
   endtask

   task automatic t_readonly;
      wr(8'h38, 32'hFFFF_0000);
      rd(8'h38); check("R5 enable ignores write", rv, 32'h0000_00CF);
      irq_lines = 32'h0000_0A05;
      wr(8'h3C, 32'h1234_5678);
      rd(8'h3C); check("R5 status ignores write", rv, 32'h0000_0A05);
   endtask

   task automatic t_status;
      irq_lines = 32'h5A5A_0001;
      @(negedge clk);
      rd(8'h3C); check("R10 status follows lines", rv, 32'h5A5A_0001);
      irq_lines = 32'h0;
      @(negedge clk);
      rd(8'h3C); check("R10 status cleared", rv, 32'h0);
   endtask

   task automatic t_self_reset;
      // bit 2 is 1 after reset: rewrite with it set, no request
      @(negedge clk);
      req = 1'b1; we = 1'b1; addr = 8'h04; wdata = 32'h1384;
      @(negedge clk);
      req = 1'b0; we = 1'b0;
      check("R7 no request when bit already set", {31'd0, sys_reset_req}, 32'd0);
      wr(8'h04, 32'h1380);
      check("R7 no request on clearing", {31'd0, sys_reset_req}, 32'd0);
      @(negedge clk);
      req = 1'b1; we = 1'b1; addr = 8'h04; wdata = 32'h0000_0004;
      @(negedge clk);
      req = 1'b0; we = 1'b0;
      check("R6 request after 0->1", {31'd0, sys_reset_req}, 32'd1);
      @(negedge clk);
      check("R6 request lasts one cycle", {31'd0, sys_reset_req}, 32'd0);
      rd(8'h04); check("R2 gencfg stored", rv, 32'h4);
      wr(8'h00, 32'h4);
      check("R7 other offset no request", {31'd0, sys_reset_req}, 32'd0);
   endtask

   task automatic t_unmapped;
      rd(8'h70); check("R8 miss hit low", {31'd0, rh}, 32'd0);
      check("R8 miss reads zero", rv, 32'h0);
      rd(8'h11); check("R8 misaligned hit low", {31'd0, rh}, 32'd0);
      check("R8 misaligned reads zero", rv, 32'h0);
      wr(8'h11, 32'hFFFF_FFFF);
      rd(8'h10); check("R8 misaligned write ignored", rv, 32'h0);
      wr(8'h70, 32'hFFFF_FFFF);
      rd(8'h6C); check("R8 out-of-window write ignored", rv, 32'h0123_4567);
      rd(8'hFC); check("R8 top offset miss", {31'd0, rh}, 32'd0);
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog: got 0x00000000 expected 0x00000001");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R6 no request after reset", {31'd0, sys_reset_req}, 32'd0);
      t_reset_values();
      t_plain_rw();
      t_enable_set();
      t_enable_clear();
      t_readonly();
      t_status();
      t_self_reset();
      t_unmapped();
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule